// File: doc/BRIEF.md
# Outstanding Load Miss Tracker

This block lets an in-order pipeline keep issuing instructions after a load misses in the data cache. The memory stage reports each miss with its word address and the register it will write. The block records the miss in a small table and marks that register as empty. Any later instruction that reads an empty register is held in decode. When memory returns a word, its address is matched against the table. The data goes out on a register write port, the register becomes full again, and the table entry is released.

The block is one module with no internal pipelining. All stall and writeback outputs are combinational functions of the current inputs and of the state held at the start of the cycle. Flushing younger instructions after a miss, the cache itself and the memory controller belong to the surrounding pipeline.

Top module: `load_miss_tracker`

## Requirements
- R1: After reset every register reads full and every table entry is free. No source query stalls, and four misses to distinct nonzero registers are all accepted.
- R2: A miss whose destination is nonzero and not already empty is accepted when an entry is free. From the next cycle that register reads empty.
- R3: When more than one entry is free, an accepted miss takes the free entry with the lowest index (index 0 is the lowest).
- R4: When no entry is free, `alloc_stall` is high in the same cycle as `alloc_req`, and the miss is not recorded.
- R5: A miss whose destination register already reads empty is refused with `alloc_stall` and changes nothing.
- R6: Register 0 never reads empty and never causes a decode stall. A miss to register 0 still occupies an entry until its fill returns.
- R7: `dec_stall` is high exactly when either source register reads empty in the state held at the start of the cycle.
- R8: A fill whose address equals that of a valid entry drives `wb_valid` high in the same cycle, with `wb_rd` set to that entry's register and `wb_data` equal to `fill_data`. From the next cycle the register reads full and the entry is free.
- R9: A fill whose address matches no valid entry leaves `wb_valid` low and changes no state.
- R10: In a cycle with both a miss and a matching fill, the entry and the register released by the fill count as available when the miss is judged.
- R11: When several valid entries hold the fill's address, the fill retires only the one with the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Load miss reported by the memory stage |
| alloc_addr | input | ADDR_W | Word address of the missing load |
| alloc_rd | input | RIDX_W | Destination register of the missing load |
| alloc_stall | output | 1 | Miss cannot be recorded this cycle |
| src_a | input | RIDX_W | First source register read in decode |
| src_b | input | RIDX_W | Second source register read in decode |
| dec_stall | output | 1 | A decode source register is empty |
| fill_valid | input | 1 | Memory returns a word |
| fill_addr | input | ADDR_W | Address of the returned word |
| fill_data | input | DATA_W | Returned word |
| wb_valid | output | 1 | Register write of returned data |
| wb_rd | output | RIDX_W | Register to write |
| wb_data | output | DATA_W | Data to write |

## Verification
The bench targets these corner cases:
- Duplicate addresses in the table. A wrong priority encoder would write the newer load's register first.
- A fill and a miss in the same cycle while the table is full. A design that judges the miss before releasing the entry would stall needlessly, and one that lets the miss overwrite the entry would lose it.
- A second miss to an already empty register. If accepted, the first fill would clear a register that still waits on a second miss.
- Misses to register 0 and fills to unknown addresses. These would otherwise create a permanent decode stall or a spurious write.

// File: rtl/load_miss_tracker.sv
module load_miss_tracker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  parameter int NREGS   = 32,
  localparam int RIDX_W = $clog2(NREGS),
  localparam int EIDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [RIDX_W-1:0] alloc_rd,
  output logic              alloc_stall,
  input  logic [RIDX_W-1:0] src_a,
  input  logic [RIDX_W-1:0] src_b,
  output logic              dec_stall,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_rd,
  output logic [DATA_W-1:0] wb_data
);

  logic [ENTRIES-1:0] ent_vld;
  logic [ADDR_W-1:0]  ent_addr [ENTRIES];
  logic [RIDX_W-1:0]  ent_rd   [ENTRIES];
  logic [NREGS-1:0]   reg_empty;

  logic [ENTRIES-1:0] hit_vec;
  logic               fill_hit;
  logic [EIDX_W-1:0]  fill_idx;
  logic [ENTRIES-1:0] still_busy;
  logic               any_free;
  logic [EIDX_W-1:0]  free_idx;
  logic               rd_busy;
  logic               alloc_ok;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      hit_vec[i] = fill_valid && ent_vld[i] && (ent_addr[i] == fill_addr);
  end

  always_comb begin
    fill_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) fill_idx = EIDX_W'(i);
  end

  assign fill_hit = |hit_vec;

  always_comb begin
    still_busy = ent_vld;
    if (fill_hit) still_busy[fill_idx] = 1'b0;
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!still_busy[i]) free_idx = EIDX_W'(i);
  end

  assign any_free = ~&still_busy;

  assign rd_busy = (alloc_rd != '0) && reg_empty[alloc_rd] &&
                   !(fill_hit && ent_rd[fill_idx] == alloc_rd);

  assign alloc_stall = alloc_req && (!any_free || rd_busy);
  assign alloc_ok    = alloc_req && !alloc_stall;

  assign dec_stall = reg_empty[src_a] || reg_empty[src_b];

  assign wb_valid = fill_hit;
  assign wb_rd    = fill_hit ? ent_rd[fill_idx] : '0;
  assign wb_data  = fill_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld   <= '0;
      reg_empty <= '0;
    end else begin
      if (fill_hit) begin
        ent_vld[fill_idx]           <= 1'b0;
        reg_empty[ent_rd[fill_idx]] <= 1'b0;
      end
      if (alloc_ok) begin
        ent_vld[free_idx] <= 1'b1;
        if (alloc_rd != '0) reg_empty[alloc_rd] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_ok) begin
      ent_addr[free_idx] <= alloc_addr;
      ent_rd[free_idx]   <= alloc_rd;
    end
  end

endmodule

// File: rtl/load_miss_tracker_chk.sv
module load_miss_tracker_chk #(
  parameter int ENTRIES = 4,
  parameter int NREGS   = 32,
  parameter int RIDX_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alloc_req,
  input logic [RIDX_W-1:0]  alloc_rd,
  input logic               alloc_stall,
  input logic               fill_valid,
  input logic               wb_valid,
  input logic [RIDX_W-1:0]  wb_rd,
  input logic [ENTRIES-1:0] ent_vld,
  input logic [NREGS-1:0]   reg_empty
);

  assert_zero_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_empty[0]);

  assert_stall_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall |-> alloc_req);

  assert_accept_marks_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_stall && alloc_rd != '0) |=> reg_empty[$past(alloc_rd)]);

  assert_accept_holds_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_stall) |=> (ent_vld != '0));

  assert_wb_needs_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> fill_valid);

  assert_wb_marks_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(alloc_req && !alloc_stall && alloc_rd == wb_rd))
      |=> !reg_empty[$past(wb_rd)]);

  assert_full_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && &ent_vld && !wb_valid) |-> alloc_stall);

endmodule

bind load_miss_tracker load_miss_tracker_chk #(
  .ENTRIES(ENTRIES), .NREGS(NREGS), .RIDX_W(RIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_rd(alloc_rd),
  .alloc_stall(alloc_stall), .fill_valid(fill_valid), .wb_valid(wb_valid),
  .wb_rd(wb_rd), .ent_vld(ent_vld), .reg_empty(reg_empty)
);

// File: tb/test_load_miss_tracker.sv
module test_load_miss_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, NE = 4, NR = 32, RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_req = 1'b0;
  logic [AW-1:0] alloc_addr = '0;
  logic [RW-1:0] alloc_rd = '0;
  logic          alloc_stall;
  logic [RW-1:0] src_a = '0, src_b = '0;
  logic          dec_stall;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic          wb_valid;
  logic [RW-1:0] wb_rd;
  logic [DW-1:0] wb_data;

  int n_vec = 0, n_bad = 0;

  bit          m_vld [NE];
  logic [AW-1:0] m_addr [NE];
  logic [RW-1:0] m_rd [NE];
  bit          m_empty [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  load_miss_tracker #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE), .NREGS(NR)) i_load_miss_tracker (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_addr(alloc_addr),
    .alloc_rd(alloc_rd), .alloc_stall(alloc_stall), .src_a(src_a), .src_b(src_b),
    .dec_stall(dec_stall), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_data(fill_data), .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data));

  function automatic int find_hit();
    for (int i = 0; i < NE; i++)
      if (fill_valid && m_vld[i] && m_addr[i] == fill_addr) return i;
    return -1;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit ar, logic [AW-1:0] aa, logic [RW-1:0] ard,
                      logic [RW-1:0] sa, logic [RW-1:0] sb,
                      bit fv, logic [AW-1:0] fa, logic [DW-1:0] fd, string tag);
    int  h, fr;
    bit  busy, exp_stall, vld_after [NE];
    @(negedge clk);
    alloc_req = ar; alloc_addr = aa; alloc_rd = ard;
    src_a = sa; src_b = sb;
    fill_valid = fv; fill_addr = fa; fill_data = fd;
    #1;
    h = find_hit();
    for (int i = 0; i < NE; i++) vld_after[i] = m_vld[i] && (i != h);
    fr = -1;
    for (int i = NE - 1; i >= 0; i--) if (!vld_after[i]) fr = i;
    busy = (ard != 0) && m_empty[ard] && !(h >= 0 && m_rd[h] == ard);
    exp_stall = ar && (fr < 0 || busy);
    check(tag, "alloc_stall", {31'b0, alloc_stall}, {31'b0, exp_stall});
    check(tag, "dec_stall", {31'b0, dec_stall}, {31'b0, (m_empty[sa] || m_empty[sb])});
    check(tag, "wb_valid", {31'b0, wb_valid}, {31'b0, (h >= 0)});
    if (h >= 0) begin
      check(tag, "wb_rd", {27'b0, wb_rd}, {27'b0, m_rd[h]});
      check(tag, "wb_data", wb_data, fd);
    end
    if (h >= 0) begin m_vld[h] = 0; m_empty[m_rd[h]] = 0; end
    if (ar && !exp_stall) begin
      m_vld[fr] = 1; m_addr[fr] = aa; m_rd[fr] = ard;
      if (ard != 0) m_empty[ard] = 1;
    end
  endtask

  task automatic idle(logic [RW-1:0] sa, logic [RW-1:0] sb, string tag);
    step(0, 0, 0, sa, sb, 0, 0, 0, tag);
  endtask

  task automatic alloc(logic [AW-1:0] a, logic [RW-1:0] rd, string tag);
    step(1, a, rd, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    step(0, 0, 0, 0, 0, 1, a, d, tag);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin m_vld[i] = 0; m_addr[i] = '0; m_rd[i] = '0; end
    for (int r = 0; r < NR; r++) m_empty[r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    idle(31, 1, "R1");
    idle(0, 17, "R1");
    alloc(32'h100, 5, "R2");
    idle(5, 0, "R2");
    alloc(32'h200, 5, "R5");
    idle(0, 5, "R5");
    alloc(32'h300, 0, "R6");
    idle(0, 0, "R6");
    alloc(32'h100, 6, "R11");
    alloc(32'h400, 7, "R1");
    alloc(32'h500, 8, "R4");
    idle(8, 7, "R4");
    fill(32'h100, 32'hA5A5_0001, "R11");
    idle(5, 6, "R8");
    alloc(32'h500, 9, "R3");
    step(1, 32'h600, 7, 7, 9, 1, 32'h400, 32'h1234_5678, "R10");
    idle(7, 0, "R10");
    fill(32'h300, 32'h0BAD_0003, "R6");
    fill(32'h100, 32'h0BAD_0006, "R8");
    alloc(32'h100, 10, "R3");
    alloc(32'h100, 11, "R3");
    fill(32'h100, 32'hCAFE_000A, "R3");
    idle(10, 11, "R3");
    fill(32'h999, 32'hDEAD_BEEF, "R9");
    idle(9, 11, "R9");

    void'($urandom(32'd20240517));
    for (int k = 0; k < 3000; k++) begin
      bit ar, fv;
      logic [AW-1:0] fa;
      int pick;
      ar = ($urandom % 100) < 45;
      fv = ($urandom % 100) < 45;
      fa = 32'h40 * ($urandom % 6);
      if (($urandom % 100) < 70) begin
        pick = $urandom % NE;
        if (m_vld[pick]) fa = m_addr[pick];
      end
      step(ar, 32'h40 * ($urandom % 6), RW'($urandom % 12),
           RW'($urandom % 12), RW'($urandom % 12), fv, fa, $urandom, "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule